// File: doc/BRIEF.md
# Dual Page-Walker Occupancy Counters

This block counts how a core's two page-miss handlers are used. On every clock it looks at each walker's busy flag, its request-type tag and its completion pulse. It adds the results into one counter set for each tracked request type: data load, data store and instruction fetch. Each set holds three counters:

- a pending-occupancy counter, which adds the number of matching walkers that are busy;
- an active-cycle counter, which adds one whenever at least one matching walker is busy;
- a completed-walk counter, which adds the number of matching completions.

Software reads a counter through a select port. Dividing pending occupancy by completed walks gives the mean walk latency. Dividing pending occupancy by active cycles gives the mean walk overlap.

Walks that carry the prefetch tag are tracked by none of the sets. A synchronous clear zeroes all counters at once. Counter width and walker count are parameters, with defaults of 48 bits and two walkers.

Top module: `pwo_top`

## Requirements
- R1: Reset and `clear` each zero every counter on the next clock edge. When `clear` is high in a cycle, the walker activity in that same cycle is not counted.
- R2: The pending counter of a set adds the number of walkers that are busy and tagged with that set's type. The step is 0, 1 or 2 per cycle.
- R3: The active counter of a set adds exactly 1 in any cycle where one or both walkers are busy with that set's type, and 0 otherwise.
- R4: The completed counter of a set adds the number of completion pulses from walkers tagged with that set's type. When both walkers complete in the same cycle, it adds 2.
- R5: Tag encoding is 0 = load, 1 = store, 2 = fetch and 3 = prefetch. Walker 0 uses `walk_tag[1:0]` and walker 1 uses `walk_tag[3:2]`. Prefetch-tagged activity changes no counter.
- R6: A busy flag and a completion pulse in the same cycle are both counted. A one-cycle walk therefore adds 1 to pending and 1 to completed. A completion pulse is counted even without a busy flag.
- R7: `rd_data` shows the counter picked by `rd_set` (0 = load, 1 = store, 2 = fetch) and `rd_kind` (0 = pending, 1 = active, 2 = completed). It is combinational from the counters, so activity in a cycle is visible right after that cycle's clock edge. `rd_set` = 3 or `rd_kind` = 3 returns 0.
- R8: Counters wrap modulo 2^CW on overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_busy | input | NWALK | Busy flag per walker |
| walk_tag | input | 2*NWALK | Request-type tag per walker, 2 bits each |
| walk_done | input | NWALK | Completion pulse per walker |
| clear | input | 1 | Synchronous clear of all counters |
| rd_set | input | 2 | Counter set select |
| rd_kind | input | 2 | Counter kind select |
| rd_data | output | CW | Selected counter value |

## Verification
Walker activity that is present before clock edge N shows up in the counters right after edge N. The read port adds no register of its own, so the effect is visible in the half cycle after that edge. The bench changes stimulus on falling edges and updates its model at the rising edge that consumes the stimulus. At the next falling edge it sweeps every set and kind, settling briefly after each select change, and compares the result with its model. A clear driven in a cycle is expected to show all zeros at the next falling edge, with that cycle's activity dropped. A narrow 4-bit instance checks wrap-around within a few cycles.

// File: rtl/pwo_pkg.sv
package pwo_pkg;

    localparam int TAG_W  = 2;
    localparam int NSETS  = 3;
    localparam int INC_W  = 4;

    typedef enum logic [TAG_W-1:0] {
        TAG_LOAD  = 2'd0,
        TAG_STORE = 2'd1,
        TAG_FETCH = 2'd2,
        TAG_PREF  = 2'd3
    } walk_tag_e;

    typedef enum logic [1:0] {
        KIND_PEND = 2'd0,
        KIND_ACT  = 2'd1,
        KIND_CMPL = 2'd2,
        KIND_NONE = 2'd3
    } ctr_kind_e;

    // per-cycle increments for one counter set
    typedef struct packed {
        logic [INC_W-1:0] pend;
        logic             act;
        logic [INC_W-1:0] cmpl;
    } set_inc_t;

    function automatic logic [INC_W-1:0] bump(input logic [INC_W-1:0] v, input logic hit);
        return hit ? v + INC_W'(1) : v;
    endfunction

endpackage

// File: rtl/pwo_match.sv
module pwo_match
    import pwo_pkg::*;
#(
    parameter int NWALK  = 2,
    parameter int SET_ID = 0
) (
    input  logic [NWALK-1:0]       busy,
    input  logic [TAG_W*NWALK-1:0] tags,
    input  logic [NWALK-1:0]       done,
    output set_inc_t               inc
);

    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(SET_ID);

    always_comb begin
        inc = '0;
        for (int w = 0; w < NWALK; w++) begin
            if (tags[TAG_W*w +: TAG_W] == MY_TAG) begin
                inc.pend = bump(inc.pend, busy[w]);
                inc.cmpl = bump(inc.cmpl, done[w]);
            end
        end
        inc.act = (inc.pend != '0);
    end

endmodule

// File: rtl/pwo_counters.sv
module pwo_counters
    import pwo_pkg::*;
#(
    parameter int CW    = 48,
    parameter int NWALK = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  set_inc_t      inc,
    output logic [CW-1:0] pend,
    output logic [CW-1:0] act,
    output logic [CW-1:0] cmpl
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend <= '0;
            act  <= '0;
            cmpl <= '0;
        end else begin
            pend <= pend + CW'(inc.pend);
            act  <= act  + CW'(inc.act);
            cmpl <= cmpl + CW'(inc.cmpl);
        end
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pend == '0 && act == '0 && cmpl == '0));

    // R2
    pend_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (CW'(pend - $past(pend)) <= CW'(NWALK)));

    // R3
    act_link_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((CW'(act - $past(act)) == CW'(1)) == (CW'(pend - $past(pend)) != '0)));

    // R4
    cmpl_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (CW'(cmpl - $past(cmpl)) <= CW'(NWALK)));

endmodule

// File: rtl/pwo_readmux.sv
module pwo_readmux
    import pwo_pkg::*;
#(
    parameter int CW = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] pend_a [NSETS],
    input  logic [CW-1:0] act_a  [NSETS],
    input  logic [CW-1:0] cmpl_a [NSETS],
    input  logic [1:0]    rd_set,
    input  logic [1:0]    rd_kind,
    output logic [CW-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NSETS; s++) begin
            if (rd_set == 2'(s)) begin
                unique case (ctr_kind_e'(rd_kind))
                    KIND_PEND: rd_data = pend_a[s];
                    KIND_ACT:  rd_data = act_a[s];
                    KIND_CMPL: rd_data = cmpl_a[s];
                    default:   rd_data = '0;
                endcase
            end
        end
    end

    // R7
    bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_set == 2'd3 || rd_kind == 2'd3) |-> rd_data == '0);

endmodule

// File: rtl/pwo_top.sv
module pwo_top
    import pwo_pkg::*;
#(
    parameter int CW    = 48,
    parameter int NWALK = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NWALK-1:0]       walk_busy,
    input  logic [TAG_W*NWALK-1:0] walk_tag,
    input  logic [NWALK-1:0]       walk_done,
    input  logic                   clear,
    input  logic [1:0]             rd_set,
    input  logic [1:0]             rd_kind,
    output logic [CW-1:0]          rd_data
);

    logic [CW-1:0] pend_a [NSETS];
    logic [CW-1:0] act_a  [NSETS];
    logic [CW-1:0] cmpl_a [NSETS];

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        set_inc_t inc;

        pwo_match #(.NWALK(NWALK), .SET_ID(s)) u_match (
            .busy (walk_busy),
            .tags (walk_tag),
            .done (walk_done),
            .inc  (inc)
        );

        pwo_counters #(.CW(CW), .NWALK(NWALK)) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .clear (clear),
            .inc   (inc),
            .pend  (pend_a[s]),
            .act   (act_a[s]),
            .cmpl  (cmpl_a[s])
        );
    end

    pwo_readmux #(.CW(CW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .pend_a  (pend_a),
        .act_a   (act_a),
        .cmpl_a  (cmpl_a),
        .rd_set  (rd_set),
        .rd_kind (rd_kind),
        .rd_data (rd_data)
    );

endmodule

// File: tb/pwo_top_test.sv
`timescale 1ns/1ps
module pwo_top_test;

    localparam int CW = 48;
    localparam int NW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NW-1:0] busy = '0;
    logic [2*NW-1:0] tag = '0;
    logic [NW-1:0] done = '0;
    logic          clr = 1'b0;
    logic [1:0]    rsel = '0;
    logic [1:0]    rkind = '0;
    logic [CW-1:0] rdata;

    logic [1:0] n_busy = '0;
    logic [3:0] n_tag = '0;
    logic [1:0] n_done = '0;
    logic [1:0] n_kind = '0;
    logic [3:0] n_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [CW-1:0] exp_p [3];
    logic [CW-1:0] exp_a [3];
    logic [CW-1:0] exp_c [3];

    always #2.5 clk = ~clk;

    pwo_top #(.CW(CW), .NWALK(NW)) uut (
        .clk(clk), .rst(rst), .walk_busy(busy), .walk_tag(tag),
        .walk_done(done), .clear(clr), .rd_set(rsel), .rd_kind(rkind),
        .rd_data(rdata));

    pwo_top #(.CW(4), .NWALK(2)) narrow (
        .clk(clk), .rst(rst), .walk_busy(n_busy), .walk_tag(n_tag),
        .walk_done(n_done), .clear(1'b0), .rd_set(2'd0), .rd_kind(n_kind),
        .rd_data(n_data));

    function automatic int hits(input logic [NW-1:0] flags, input logic [2*NW-1:0] t, input int s);
        int n = 0;
        for (int w = 0; w < NW; w++)
            if (flags[w] && t[2*w +: 2] == 2'(s)) n++;
        return n;
    endfunction

    task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic model_zero();
        for (int s = 0; s < 3; s++) begin
            exp_p[s] = '0; exp_a[s] = '0; exp_c[s] = '0;
        end
    endtask

    task automatic sweep();
        for (int s = 0; s < 3; s++) begin
            rsel = 2'(s);
            rkind = 2'd0; #0.2; check("R2 pending", rdata, exp_p[s]);
            rkind = 2'd1; #0.2; check("R3 active", rdata, exp_a[s]);
            rkind = 2'd2; #0.2; check("R4 completed", rdata, exp_c[s]);
        end
    endtask

    // drive after a falling edge, model at the rising edge, sweep at the next falling edge
    task automatic cycle(input logic [NW-1:0] b, input logic [2*NW-1:0] t,
                         input logic [NW-1:0] d, input logic c);
        busy = b; tag = t; done = d; clr = c;
        @(posedge clk);
        if (c) model_zero();
        else begin
            for (int s = 0; s < 3; s++) begin
                exp_p[s] += CW'(hits(b, t, s));
                exp_a[s] += CW'(hits(b, t, s) > 0 ? 1 : 0);
                exp_c[s] += CW'(hits(d, t, s));
            end
        end
        @(negedge clk);
        busy = '0; done = '0; clr = 1'b0;
        sweep();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_zero();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        sweep();

        // R2 R3 both walkers on load
        cycle(2'b11, 4'b00_00, 2'b00, 1'b0);
        // R2 mixed load/store
        cycle(2'b11, 4'b01_00, 2'b00, 1'b0);
        // R5 prefetch-only activity ignored
        cycle(2'b11, 4'b11_11, 2'b11, 1'b0);
        // R4 both walkers complete fetch together
        cycle(2'b00, 4'b10_10, 2'b11, 1'b0);
        // R6 one-cycle store walk on walker 1, done without busy on walker 0
        cycle(2'b10, 4'b01_00, 2'b11, 1'b0);
        // R1 clear wins over same-cycle activity
        cycle(2'b11, 4'b00_00, 2'b11, 1'b1);
        check("R1 cleared load pending", exp_p[0], '0);

        // R7 invalid selects read zero
        cycle(2'b11, 4'b00_10, 2'b01, 1'b0);
        rsel = 2'd3; rkind = 2'd0; #0.2; check("R7 set 3", rdata, '0);
        rsel = 2'd0; rkind = 2'd3; #0.2; check("R7 kind 3", rdata, '0);
        rsel = 2'd2; rkind = 2'd3; #0.2; check("R7 kind 3 fetch", rdata, '0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            cycle(2'($urandom), 4'($urandom), 2'($urandom),
                  ($urandom % 40) == 0);
        end

        // R8 wrap on the 4-bit instance
        n_busy = 2'b11; n_tag = 4'b0000; n_done = 2'b11;
        repeat (10) @(posedge clk);
        @(negedge clk);
        n_busy = '0; n_done = '0;
        n_kind = 2'd0; #0.2; check("R8 pending wrap", CW'(n_data), CW'(4));
        n_kind = 2'd1; #0.2; check("R8 active", CW'(n_data), CW'(10));
        n_kind = 2'd2; #0.2; check("R8 completed wrap", CW'(n_data), CW'(4));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule